// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32.768 kHz time base into periodic events for a real-time clock. The 32.768 kHz time base arrives as a single-cycle enable on the system clock. A free-running counter advances on each of those enables. The generator fires an event each time the counter lands on a multiple of the selected period. The period is a power of two, in 32.768 kHz cycles, chosen by a 4-bit rate code. Because the counter never stops or restarts, events always fall on period boundaries of absolute time, whatever the moment the rate was chosen.

An event does up to two things, depending on the enables:
- With the periodic interrupt enable set, it produces a one-cycle strobe to set the periodic flags and a one-cycle interrupt request.
- With the square-wave enable set, it produces a single one-cycle pulse rather than a 50% duty waveform.

The rate code and both enables are used combinationally on every clock. A change to any of them therefore applies from the next counter advance. Nothing is retimed or buffered.

Top module: `periodic_rate_gen`

## Requirements
- R1: After reset all three outputs are low, and the internal 32.768 kHz counter is zero. The first advance therefore brings the counter to 1, and the first event of a period P falls on the P-th advance.
- R2: The counter advances only in a clock cycle where `tick32k_i` is high. No event is produced in a cycle where `tick32k_i` is low.
- R3: For rate codes 3 to 15 the period is 2^(code-1) advances. An event occurs on the advance that brings the counter (15 bits, wrapping) to a value whose low (code-1) bits are all zero.
- R4: Rate code 1 behaves as code 8, with a period of 128 advances. Rate code 2 behaves as code 9, with a period of 256 advances.
- R5: Rate code 0 stops the generator: no output pulses, whatever the enables are.
- R6: With both `pie_en_i` and `sqw_en_i` low, no output pulses, whatever the rate code is.
- R7: When an event occurs with `pie_en_i` high, `flag_set_o` and `irq_o` are both high for exactly one clock, in the cycle after the clock edge that sampled the advance.
- R8: When an event occurs with `sqw_en_i` high, `sqw_pulse_o` is high for exactly one clock, in the same cycle position as in R7. It never stays high for two consecutive cycles.
- R9: A change of the rate code or of the enables applies at the very next clock edge. Event alignment follows the absolute counter value, not the time of the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick32k_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| rate_code_i | input | 4 | Rate select code (0 = stopped) |
| pie_en_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Square-wave pulse enable |
| flag_set_o | output | 1 | Strobe to set the periodic flags |
| irq_o | output | 1 | Interrupt request pulse |
| sqw_pulse_o | output | 1 | Square-wave output pulse |

## Verification
The bench builds the block with its defaults: a 4-bit code and a 15-bit counter. With these values the slowest rate, 16384 advances, is reached inside the run, and the counter wraps past 32767 at least once. This shows that event alignment survives the wrap. With advances on most clocks, the 128- and 256-advance aliases and the fastest 4-advance rate each produce many events. This leaves room for random code and enable changes in the middle of a period.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int RATE_CODE_W = 4;
  localparam int SHIFT_W     = 5;
  // codes 1 and 2 are folded onto slower rates
  localparam logic [SHIFT_W-1:0] ALIAS1_SHIFT = SHIFT_W'(7);
  localparam logic [SHIFT_W-1:0] ALIAS2_SHIFT = SHIFT_W'(8);

  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [RATE_CODE_W-1:0] code);
    logic [SHIFT_W-1:0] s;
    case (code)
      4'd0:    s = '0;
      4'd1:    s = ALIAS1_SHIFT;
      4'd2:    s = ALIAS2_SHIFT;
      default: s = SHIFT_W'(code) - SHIFT_W'(1);
    endcase
    return s;
  endfunction
endpackage

// File: rtl/prg_rate_decode.sv
module prg_rate_decode
  import prg_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic [RATE_CODE_W-1:0] code_i,
  output logic                   run_o,
  output logic [CNT_W-1:0]       mask_o
);
  logic [SHIFT_W-1:0] shift;

  assign shift = code_to_shift(code_i);
  assign run_o = (code_i != '0);

  for (genvar i = 0; i < CNT_W; i++) begin : g_mask
    assign mask_o[i] = (shift > SHIFT_W'(i));
  end
endmodule

// File: rtl/prg_timebase.sv
module prg_timebase #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_nxt_o;
  end

  assert_hold_without_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_q));
endmodule

// File: rtl/prg_pulse_out.sv
module prg_pulse_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic pie_en_i,
  input  logic sqw_en_i,
  output logic flag_set_o,
  output logic irq_o,
  output logic sqw_pulse_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_set_o  <= 1'b0;
      irq_o       <= 1'b0;
      sqw_pulse_o <= 1'b0;
    end else begin
      flag_set_o  <= fire_i & pie_en_i;
      irq_o       <= fire_i & pie_en_i;
      sqw_pulse_o <= fire_i & sqw_en_i;
    end
  end
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
  import prg_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick32k_i,
  input  logic [RATE_CODE_W-1:0] rate_code_i,
  input  logic                   pie_en_i,
  input  logic                   sqw_en_i,
  output logic                   flag_set_o,
  output logic                   irq_o,
  output logic                   sqw_pulse_o
);
  localparam int MAX_SHIFT = (1 << RATE_CODE_W) - 2;

  logic             run;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_nxt;
  logic             fire;

  prg_rate_decode #(.CNT_W(CNT_W)) u_dec (
    .code_i (rate_code_i),
    .run_o  (run),
    .mask_o (mask)
  );

  prg_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (tick32k_i),
    .cnt_nxt_o (cnt_nxt)
  );

  // boundary reached on this advance
  assign fire = tick32k_i & run & (pie_en_i | sqw_en_i) & ((cnt_nxt & mask) == '0);

  prg_pulse_out u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_i      (fire),
    .pie_en_i    (pie_en_i),
    .sqw_en_i    (sqw_en_i),
    .flag_set_o  (flag_set_o),
    .irq_o       (irq_o),
    .sqw_pulse_o (sqw_pulse_o)
  );

  initial assert (CNT_W > MAX_SHIFT) else $error("CNT_W too small for slowest rate");

  assert_pulse_needs_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_set_o || sqw_pulse_o) |-> $past(tick32k_i));
  assert_code0_silent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_set_o || sqw_pulse_o) |-> ($past(rate_code_i) != '0));
  assert_irq_needs_pie_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || flag_set_o) |-> $past(pie_en_i));
  assert_irq_with_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_set_o);
  assert_sqw_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sqw_pulse_o |-> $past(sqw_en_i));
  assert_sqw_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sqw_pulse_o |=> !sqw_pulse_o);
endmodule

// File: tb/sim_periodic_rate_gen.sv
`timescale 1ns/1ps
module sim_periodic_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] code = 4'd0;
  logic       pie = 1'b0;
  logic       sqe = 1'b0;
  logic       flag_set, irq, sqw;

  int vectors = 0;
  int bad = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  periodic_rate_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick32k_i(tick), .rate_code_i(code),
    .pie_en_i(pie), .sqw_en_i(sqe),
    .flag_set_o(flag_set), .irq_o(irq), .sqw_pulse_o(sqw)
  );

  function automatic int exp_period(input logic [3:0] c);
    if (c == 4'd0) return 0;
    if (c == 4'd1) return 128;
    if (c == 4'd2) return 256;
    return 1 << (int'(c) - 1);
  endfunction

  task automatic cmp(input logic act, input logic exp, input string what, input string tag);
    vectors++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0b expected %0b (code %0d, count %0d)", tag, what, act, exp, code, m_cnt);
    end
  endtask

  // drive at negedge, check at the following negedge
  task automatic step(input logic tk, input logic [3:0] c, input logic p, input logic s, input string tag);
    int  nxt, per;
    logic fire;
    tick = tk; code = c; pie = p; sqe = s;
    per  = exp_period(c);
    nxt  = (m_cnt + 1) & 32'h7FFF;
    fire = tk && (per != 0) && (p || s) && ((nxt % per) == 0);
    if (tk) m_cnt = nxt;
    @(posedge clk);
    @(negedge clk);
    cmp(flag_set, fire && p, "flag_set_o", tag);
    cmp(irq,      fire && p, "irq_o", tag);
    cmp(sqw,      fire && s, "sqw_pulse_o", tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    cmp(flag_set, 1'b0, "flag_set_o in reset", "R1");
    cmp(irq,      1'b0, "irq_o in reset", "R1");
    cmp(sqw,      1'b0, "sqw_pulse_o in reset", "R1");
    rst_n = 1'b1;
    @(negedge clk);
    cmp(flag_set, 1'b0, "flag_set_o after reset", "R1");

    // R1/R3/R7: fastest rate from a zero counter, first event on 4th advance
    for (int i = 0; i < 40; i++) step(1'b1, 4'd3, 1'b1, 1'b0, "R3");
    // R2: no advance, no event
    for (int i = 0; i < 20; i++) step(1'b0, 4'd3, 1'b1, 1'b1, "R2");
    // R5: code 0 silent
    for (int i = 0; i < 300; i++) step(1'b1, 4'd0, 1'b1, 1'b1, "R5");
    // R6: both enables off
    for (int i = 0; i < 100; i++) step(1'b1, 4'd4, 1'b0, 1'b0, "R6");
    // R4: aliased low codes
    for (int i = 0; i < 300; i++) step(1'b1, 4'd1, 1'b0, 1'b1, "R4");
    for (int i = 0; i < 600; i++) step(1'b1, 4'd2, 1'b1, 1'b0, "R4");
    // R3: slowest rate, full period
    for (int i = 0; i < 16500; i++) step(1'b1, 4'd15, 1'b1, 1'b1, "R3");
    // R9: rate and enable changes mid-period
    for (int i = 0; i < 240; i++)
      step(1'b1, ((i / 3) % 2) ? 4'd4 : 4'd5, (i % 7) != 0, (i % 5) == 0, "R9");
    // R8 and mixed: random traffic, past the counter wrap
    for (int i = 0; i < 24000; i++) begin
      logic [3:0] c;
      logic tk;
      c  = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(3, 7));
      tk = ($urandom_range(0, 3) != 0);
      step(tk, c, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R8");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule